// File: doc/BRIEF.md
# Floating-Point Last-Instruction Pointer Capture

This block sits next to a floating-point issue stage. For every issued floating-point instruction it can record where the instruction sits in code (selector and offset), which operand address it used (selector and offset), and an 11-bit opcode. The core presents the address of the escape byte together with the number of prefix bytes in front of it, and the block stores the address of the first prefix. When an issued instruction faults, the block raises a pending flag. It then ignores every later instruction until the flag is cleared, so the record of the faulting instruction survives until a handler reads it.

A store-environment request starts a readout of four 16-bit words. The words are handed out one per transfer under a valid/ready handshake. Configuration inputs pick between two layouts. The legacy real-mode layout holds 20-bit linear addresses and the opcode. The protected-mode layout holds selector/offset pairs and no opcode. A second input chooses whether the opcode follows every instruction or only faulting ones. A third input forces the selectors to read as zero. With these inputs the block can mimic several generations of compatibility behaviour.

Top module: `fptr_env_capture`

## Requirements
- R1: After reset the captured selectors, offsets and opcode are all zero, `exc_pending` is low and `env_valid` is low.
- R2: The stored opcode is bits [10:0] of `iss_opbytes` (low three bits of the escape byte, then the whole second byte). The five fixed escape bits [15:11] are dropped.
- R3: The stored code offset is `iss_esc_ip - iss_pfx_cnt`, taken modulo 2^16, so it points at the first prefix byte.
- R4: With `cfg_prot`=0 and `cfg_seg_zero`=0 the words are, in order: word 0 = linear code address [15:0]; word 1 = {linear code address [19:16], a zero bit, opcode[10:0]}; word 2 = linear data address [15:0]; word 3 = {linear data address [19:16], 12 zero bits}. A linear address is (selector*16 + offset) mod 2^20.
- R5: With `cfg_prot`=1 the words are, in order: code offset, code selector, data offset, data selector. No opcode appears.
- R6: With `cfg_opc_always`=1 every accepted instruction updates the opcode. With it 0 only an accepted instruction that has `iss_fault`=1 updates the opcode. Offsets and selectors update on every accepted instruction.
- R7: With `cfg_seg_zero`=1 the selectors read as zero in both layouts. In the real-mode layout words 0 and 2 then carry the plain offsets, and the high nibbles of words 1 and 3 are zero.
- R8: An accepted instruction with `iss_fault`=1 sets `exc_pending` on the following cycle. While it is set, issued instructions change nothing. A one-cycle `exc_clear` drops it.
- R9: `env_req` while idle starts a readout from the next cycle. A word stays on `env_word` until it is taken with `env_ready`. `env_last` marks word 3, and `env_valid` falls after it is taken. An `env_req` during a readout is ignored.
- R10: An instruction issued during a readout does not change the words being read. The latest such instruction is applied after the readout ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prot | input | 1 | 1 selects the protected layout, 0 the real-mode layout |
| cfg_opc_always | input | 1 | 1 tracks the opcode on every instruction |
| cfg_seg_zero | input | 1 | 1 reports selectors as zero |
| iss_valid | input | 1 | One floating-point instruction issued this cycle |
| iss_fault | input | 1 | The issued instruction raises an exception |
| iss_cs | input | 16 | Code selector of the instruction |
| iss_esc_ip | input | 16 | Offset of the escape byte |
| iss_pfx_cnt | input | 2 | Number of prefix bytes before the escape byte |
| iss_ds | input | 16 | Operand selector |
| iss_dp | input | 16 | Operand offset |
| iss_opbytes | input | 16 | Escape byte (high) and second opcode byte (low) |
| exc_clear | input | 1 | Clears the pending exception |
| exc_pending | output | 1 | An exception is pending and capture is frozen |
| env_req | input | 1 | Store-environment request |
| env_ready | input | 1 | Consumer takes the current word |
| env_valid | output | 1 | A word is offered |
| env_last | output | 1 | The offered word is the final one |
| env_word | output | 16 | Environment word |

## Verification
On every cycle the assertions check the handshake: a word that is not taken stays offered, the slot steps by one on each transfer, and `env_last` never appears without `env_valid`. They also check that the captured state holds still while a readout runs or an exception is pending, and that suppressed selectors read as zero in the protected layout. Other behaviours need the bench's scenarios. These are the exact word contents in both layouts, the prefix adjustment and its wrap, linear-address truncation, opcode tracking in fault-only mode, and a deferred capture showing up in the next readout rather than the current one.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
   localparam int ENV_WORDS = 4;

   typedef enum logic [1:0] {
      SLOT_CODE_LO = 2'd0,
      SLOT_CODE_HI = 2'd1,
      SLOT_DATA_LO = 2'd2,
      SLOT_DATA_HI = 2'd3
   } env_slot_e;
endpackage

// File: rtl/fpe_capture.sv
module fpe_capture #(
   parameter int OFF_W = 16,
   parameter int SEL_W = 16,
   parameter int OPC_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_opc_always,
   input  logic             busy,
   input  logic             in_valid,
   input  logic             in_fault,
   input  logic [SEL_W-1:0] in_cs,
   input  logic [OFF_W-1:0] in_ip,
   input  logic [SEL_W-1:0] in_ds,
   input  logic [OFF_W-1:0] in_dp,
   input  logic [OPC_W-1:0] in_opc,
   input  logic             exc_clear,
   output logic [SEL_W-1:0] cs_q,
   output logic [OFF_W-1:0] ip_q,
   output logic [SEL_W-1:0] ds_q,
   output logic [OFF_W-1:0] dp_q,
   output logic [OPC_W-1:0] opc_q,
   output logic             exc_pend
);
   logic             hold_v, h_fault;
   logic [SEL_W-1:0] h_cs, h_ds;
   logic [OFF_W-1:0] h_ip, h_dp;
   logic [OPC_W-1:0] h_opc;

   logic frozen, accept, to_hold, direct, drain, apply_v;
   logic             a_fault;
   logic [SEL_W-1:0] a_cs, a_ds;
   logic [OFF_W-1:0] a_ip, a_dp;
   logic [OPC_W-1:0] a_opc;

   assign frozen  = exc_pend | (hold_v & h_fault);
   assign accept  = in_valid & ~frozen;
   assign to_hold = accept & (busy | hold_v);
   assign direct  = accept & ~busy & ~hold_v;
   assign drain   = hold_v & ~busy;
   assign apply_v = drain | direct;

   always_comb begin
      if (drain) begin
         a_fault = h_fault; a_cs = h_cs; a_ip = h_ip;
         a_ds = h_ds; a_dp = h_dp; a_opc = h_opc;
      end else begin
         a_fault = in_fault; a_cs = in_cs; a_ip = in_ip;
         a_ds = in_ds; a_dp = in_dp; a_opc = in_opc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q <= '0; ip_q <= '0; ds_q <= '0; dp_q <= '0; opc_q <= '0;
         exc_pend <= 1'b0;
         hold_v <= 1'b0; h_fault <= 1'b0;
         h_cs <= '0; h_ip <= '0; h_ds <= '0; h_dp <= '0; h_opc <= '0;
      end else begin
         if (exc_clear) exc_pend <= 1'b0;
         if (apply_v) begin
            cs_q <= a_cs; ip_q <= a_ip; ds_q <= a_ds; dp_q <= a_dp;
            if (cfg_opc_always | a_fault) opc_q <= a_opc;
            if (a_fault) exc_pend <= 1'b1;
         end
         if (to_hold) begin
            hold_v <= 1'b1; h_fault <= in_fault;
            h_cs <= in_cs; h_ip <= in_ip; h_ds <= in_ds;
            h_dp <= in_dp; h_opc <= in_opc;
         end else if (drain) begin
            hold_v <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fpe_env_reader.sv
module fpe_env_reader #(
   parameter int WORDS = fpe_pkg::ENV_WORDS,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             ready,
   output logic             busy,
   output logic             last,
   output logic [IDX_W-1:0] slot
);
   assign last = busy && (slot == IDX_W'(WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         slot <= '0;
      end else if (!busy) begin
         if (req) begin
            busy <= 1'b1;
            slot <= '0;
         end
      end else if (ready) begin
         if (last) busy <= 1'b0;
         else      slot <= slot + 1'b1;
      end
   end
endmodule

// File: rtl/fpe_env_format.sv
module fpe_env_format #(
   parameter int OFF_W     = 16,
   parameter int SEL_W     = 16,
   parameter int OPC_W     = 11,
   parameter int SEG_SHIFT = 4,
   localparam int WORD_W = OFF_W,
   localparam int LIN_W  = OFF_W + SEG_SHIFT,
   localparam int GAP_W  = WORD_W - SEG_SHIFT - OPC_W
) (
   input  logic              cfg_prot,
   input  logic              cfg_seg_zero,
   input  logic [SEL_W-1:0]  cs,
   input  logic [OFF_W-1:0]  ip,
   input  logic [SEL_W-1:0]  ds,
   input  logic [OFF_W-1:0]  dp,
   input  logic [OPC_W-1:0]  opc,
   input  logic [1:0]        slot,
   output logic [WORD_W-1:0] word
);
   import fpe_pkg::*;

   logic [SEL_W-1:0]  cs_eff, ds_eff;
   logic [LIN_W-1:0]  lin_c, lin_d;
   logic [WORD_W-1:0] code_hi, data_hi;

   assign cs_eff = cfg_seg_zero ? '0 : cs;
   assign ds_eff = cfg_seg_zero ? '0 : ds;
   assign lin_c  = {cs_eff, {SEG_SHIFT{1'b0}}} + LIN_W'(ip);
   assign lin_d  = {ds_eff, {SEG_SHIFT{1'b0}}} + LIN_W'(dp);

   generate
      if (GAP_W > 0) begin : g_gap
         assign code_hi = {lin_c[LIN_W-1:OFF_W], {GAP_W{1'b0}}, opc};
      end else begin : g_nogap
         assign code_hi = {lin_c[LIN_W-1:OFF_W], opc};
      end
   endgenerate
   assign data_hi = {lin_d[LIN_W-1:OFF_W], {(WORD_W - SEG_SHIFT){1'b0}}};

   always_comb begin
      unique case (env_slot_e'(slot))
         SLOT_CODE_LO: word = cfg_prot ? ip : lin_c[OFF_W-1:0];
         SLOT_CODE_HI: word = cfg_prot ? WORD_W'(cs_eff) : code_hi;
         SLOT_DATA_LO: word = cfg_prot ? dp : lin_d[OFF_W-1:0];
         default:      word = cfg_prot ? WORD_W'(ds_eff) : data_hi;
      endcase
   end
endmodule

// File: rtl/fptr_env_capture.sv
module fptr_env_capture #(
   parameter int OFF_W     = 16,
   parameter int SEL_W     = 16,
   parameter int OPC_W     = 11,
   parameter int SEG_SHIFT = 4,
   parameter int PFX_W     = 2,
   localparam int OPB_W  = 16,
   localparam int WORD_W = OFF_W,
   localparam int IDX_W  = $clog2(fpe_pkg::ENV_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_prot,
   input  logic              cfg_opc_always,
   input  logic              cfg_seg_zero,
   input  logic              iss_valid,
   input  logic              iss_fault,
   input  logic [SEL_W-1:0]  iss_cs,
   input  logic [OFF_W-1:0]  iss_esc_ip,
   input  logic [PFX_W-1:0]  iss_pfx_cnt,
   input  logic [SEL_W-1:0]  iss_ds,
   input  logic [OFF_W-1:0]  iss_dp,
   input  logic [OPB_W-1:0]  iss_opbytes,
   input  logic              exc_clear,
   output logic              exc_pending,
   input  logic              env_req,
   input  logic              env_ready,
   output logic              env_valid,
   output logic              env_last,
   output logic [WORD_W-1:0] env_word
);
   generate
      if (SEL_W != OFF_W) begin : g_bad_sel
         $error("selector and offset widths must match");
      end
      if (SEG_SHIFT + OPC_W > WORD_W) begin : g_bad_pack
         $error("opcode and linear high bits do not fit one word");
      end
      if (OPC_W > OPB_W - 5) begin : g_bad_opc
         $error("opcode would include escape bits");
      end
      if (PFX_W > OFF_W) begin : g_bad_pfx
         $error("prefix count wider than offset");
      end
   endgenerate

   logic [OFF_W-1:0] first_ip;
   logic [OPC_W-1:0] opc_bits;
   logic [SEL_W-1:0] cap_cs, cap_ds;
   logic [OFF_W-1:0] cap_ip, cap_dp;
   logic [OPC_W-1:0] cap_opc;
   logic             rd_busy;
   logic [IDX_W-1:0] rd_slot;

   assign first_ip = iss_esc_ip - OFF_W'(iss_pfx_cnt);
   assign opc_bits = iss_opbytes[OPC_W-1:0];

   fpe_capture #(.OFF_W(OFF_W), .SEL_W(SEL_W), .OPC_W(OPC_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .cfg_opc_always(cfg_opc_always), .busy(rd_busy),
      .in_valid(iss_valid), .in_fault(iss_fault), .in_cs(iss_cs), .in_ip(first_ip),
      .in_ds(iss_ds), .in_dp(iss_dp), .in_opc(opc_bits), .exc_clear(exc_clear),
      .cs_q(cap_cs), .ip_q(cap_ip), .ds_q(cap_ds), .dp_q(cap_dp), .opc_q(cap_opc),
      .exc_pend(exc_pending)
   );

   fpe_env_reader #(.WORDS(fpe_pkg::ENV_WORDS)) u_rd (
      .clk(clk), .rst_n(rst_n), .req(env_req), .ready(env_ready),
      .busy(rd_busy), .last(env_last), .slot(rd_slot)
   );

   fpe_env_format #(.OFF_W(OFF_W), .SEL_W(SEL_W), .OPC_W(OPC_W), .SEG_SHIFT(SEG_SHIFT)) u_fmt (
      .cfg_prot(cfg_prot), .cfg_seg_zero(cfg_seg_zero), .cs(cap_cs), .ip(cap_ip),
      .ds(cap_ds), .dp(cap_dp), .opc(cap_opc), .slot(rd_slot), .word(env_word)
   );

   assign env_valid = rd_busy;
endmodule

// File: rtl/fpe_env_checker.sv
module fpe_env_checker #(
   parameter int OFF_W = 16,
   parameter int SEL_W = 16,
   parameter int OPC_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_prot,
   input logic             cfg_seg_zero,
   input logic             exc_pending,
   input logic             env_ready,
   input logic             env_valid,
   input logic             env_last,
   input logic [OFF_W-1:0] env_word,
   input logic [1:0]       rd_slot,
   input logic [SEL_W-1:0] cap_cs,
   input logic [OFF_W-1:0] cap_ip,
   input logic [SEL_W-1:0] cap_ds,
   input logic [OFF_W-1:0] cap_dp,
   input logic [OPC_W-1:0] cap_opc
);
   a_r9_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      env_valid && !env_ready |=> env_valid && rd_slot == $past(rd_slot));

   a_r9_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
      env_valid && env_ready && !env_last |=> env_valid && rd_slot == $past(rd_slot) + 2'd1);

   a_r9_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      env_last && env_ready |=> !env_valid);

   a_r9_last_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
      env_last |-> env_valid);

   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pending |=> $stable(cap_ip) && $stable(cap_cs) && $stable(cap_dp)
                      && $stable(cap_ds) && $stable(cap_opc));

   a_r10_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
      env_valid |=> $stable(cap_ip) && $stable(cap_cs) && $stable(cap_dp)
                    && $stable(cap_ds) && $stable(cap_opc));

   a_r7_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
      env_valid && cfg_prot && cfg_seg_zero && rd_slot[0] |-> env_word == '0);
endmodule

bind fptr_env_capture fpe_env_checker #(.OFF_W(OFF_W), .SEL_W(SEL_W), .OPC_W(OPC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_prot(cfg_prot), .cfg_seg_zero(cfg_seg_zero),
   .exc_pending(exc_pending), .env_ready(env_ready), .env_valid(env_valid),
   .env_last(env_last), .env_word(env_word), .rd_slot(rd_slot),
   .cap_cs(cap_cs), .cap_ip(cap_ip), .cap_ds(cap_ds), .cap_dp(cap_dp), .cap_opc(cap_opc)
);

// File: tb/test_fptr_env_capture.sv
`timescale 1ns/1ps
module test_fptr_env_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_prot = 0, cfg_opc_always = 1, cfg_seg_zero = 0;
   logic        iss_valid = 0, iss_fault = 0;
   logic [15:0] iss_cs = 0, iss_esc_ip = 0, iss_ds = 0, iss_dp = 0, iss_opbytes = 0;
   logic [1:0]  iss_pfx_cnt = 0;
   logic        exc_clear = 0, exc_pending;
   logic        env_req = 0, env_ready = 0, env_valid, env_last;
   logic [15:0] env_word;

   int errs = 0, checks = 0;
   logic [15:0] m_cs = 0, m_ip = 0, m_ds = 0, m_dp = 0;
   logic [10:0] m_opc = 0;
   bit          m_pend = 0;

   always #2 clk = ~clk;

   fptr_env_capture i_fptr_env_capture (.*);

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   function automatic logic [15:0] exp_word(int k, bit prot, bit sz);
      logic [15:0] cs, ds;
      logic [19:0] lc, ld;
      cs = sz ? 16'h0 : m_cs;
      ds = sz ? 16'h0 : m_ds;
      lc = {cs, 4'h0} + {4'h0, m_ip};
      ld = {ds, 4'h0} + {4'h0, m_dp};
      if (prot) begin
         case (k) 0: return m_ip; 1: return cs; 2: return m_dp; default: return ds; endcase
      end
      case (k)
         0: return lc[15:0];
         1: return {lc[19:16], 1'b0, m_opc};
         2: return ld[15:0];
         default: return {ld[19:16], 12'h0};
      endcase
   endfunction

   task automatic model_apply(bit fault, logic [15:0] cs, logic [15:0] esc, logic [1:0] pfx,
                              logic [15:0] ds, logic [15:0] dp, logic [15:0] opb);
      if (!m_pend) begin
         m_cs = cs; m_ip = esc - 16'(pfx); m_ds = ds; m_dp = dp;
         if (cfg_opc_always || fault) m_opc = opb[10:0];
         if (fault) m_pend = 1;
      end
   endtask

   task automatic drive_issue(bit fault, logic [15:0] cs, logic [15:0] esc, logic [1:0] pfx,
                              logic [15:0] ds, logic [15:0] dp, logic [15:0] opb);
      iss_valid = 1; iss_fault = fault; iss_cs = cs; iss_esc_ip = esc;
      iss_pfx_cnt = pfx; iss_ds = ds; iss_dp = dp; iss_opbytes = opb;
   endtask

   task automatic do_issue(bit fault, logic [15:0] cs, logic [15:0] esc, logic [1:0] pfx,
                           logic [15:0] ds, logic [15:0] dp, logic [15:0] opb);
      drive_issue(fault, cs, esc, pfx, ds, dp, opb);
      step();
      iss_valid = 0; iss_fault = 0;
      model_apply(fault, cs, esc, pfx, ds, dp, opb);
      chk("R8", "exc_pending", 32'(exc_pending), 32'(m_pend));
   endtask

   task automatic do_clear();
      exc_clear = 1; step(); exc_clear = 0; m_pend = 0;
      chk("R8", "exc_pending after clear", 32'(exc_pending), 32'(0));
   endtask

   // Consumes one readout already started; words are compared with the model.
   task automatic drain(input string rq, input bit mid_req);
      int k = 0;
      int guard = 0;
      string tag;
      tag = (rq != "") ? rq : (cfg_seg_zero ? "R7" : (cfg_prot ? "R3,R5" : "R2,R3,R4"));
      while (k < 4 && guard < 64) begin
         bit rdy;
         guard++;
         chk("R9", "env_valid during readout", 32'(env_valid), 32'(1));
         chk(tag, $sformatf("word %0d", k), 32'(env_word), 32'(exp_word(k, cfg_prot, cfg_seg_zero)));
         chk("R9", "env_last", 32'(env_last), 32'(k == 3));
         rdy = ($urandom % 3 != 0) || guard > 40;
         env_ready = rdy;
         if (mid_req && k == 1) env_req = 1;
         step();
         env_req = 0;
         if (rdy) k++;
      end
      env_ready = 0;
      chk("R9", "env_valid after last word", 32'(env_valid), 32'(0));
   endtask

   task automatic read_env(input string rq);
      env_req = 1; step(); env_req = 0;
      drain(rq, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e_a7c3));
      repeat (3) step();
      rst_n = 1; step();

      // R1: reset state
      chk("R1", "exc_pending at reset", 32'(exc_pending), 32'(0));
      chk("R1", "env_valid at reset", 32'(env_valid), 32'(0));
      cfg_prot = 0; read_env("R1");
      cfg_prot = 1; read_env("R1");

      // R3 prefix wrap, R4 linear truncation
      cfg_prot = 0; cfg_opc_always = 1;
      do_issue(0, 16'hFFFF, 16'h0001, 2'd3, 16'hFFFF, 16'hFFFF, 16'hDEAD);
      chk("R3", "prefix wrap offset", 32'(m_ip), 32'h0000FFFE);
      read_env("");
      // R2: escape bits dropped
      do_issue(0, 16'h1234, 16'h0100, 2'd0, 16'h0040, 16'h0008, 16'hFFFF);
      read_env("");
      cfg_prot = 1; read_env("");
      cfg_seg_zero = 1; read_env(""); cfg_prot = 0; read_env(""); cfg_seg_zero = 0;

      // R6/R8: fault-only opcode tracking and freeze
      cfg_opc_always = 0;
      do_issue(0, 16'h2000, 16'h0010, 2'd1, 16'h3000, 16'h0020, 16'hD9F1);
      read_env("R6");
      do_issue(1, 16'h2100, 16'h0050, 2'd2, 16'h3100, 16'h0060, 16'hDEF9);
      do_issue(0, 16'h7777, 16'h7777, 2'd0, 16'h7777, 16'h7777, 16'hDC11);
      read_env("R8");
      do_clear();
      do_issue(0, 16'h4400, 16'h0400, 2'd0, 16'h4500, 16'h0500, 16'hD8C1);
      read_env("R6");
      cfg_opc_always = 1;
      do_issue(0, 16'h4400, 16'h0404, 2'd0, 16'h4500, 16'h0500, 16'hDAE9);
      read_env("R6");

      // R9: request during readout is ignored
      env_req = 1; step(); env_req = 0;
      drain("R9", 1'b1);
      step(); step();
      chk("R9", "no restart after ignored request", 32'(env_valid), 32'(0));

      // R10: captures during readout are deferred, latest wins
      env_req = 1; step(); env_req = 0;
      env_ready = 0;
      drive_issue(0, 16'hAAAA, 16'h1111, 2'd1, 16'hBBBB, 16'h2222, 16'hD801); step();
      drive_issue(0, 16'hCCCC, 16'h3333, 2'd2, 16'hEEEE, 16'h4444, 16'hD902); step();
      iss_valid = 0;
      drain("R10", 1'b0);
      model_apply(0, 16'hAAAA, 16'h1111, 2'd1, 16'hBBBB, 16'h2222, 16'hD801);
      model_apply(0, 16'hCCCC, 16'h3333, 2'd2, 16'hEEEE, 16'h4444, 16'hD902);
      step(); step();
      read_env("R10");

      // constrained random mix
      for (int n = 0; n < 300; n++) begin
         int r = $urandom % 10;
         if (r < 6) begin
            do_issue(($urandom % 8) == 0, 16'($urandom), 16'($urandom), 2'($urandom),
                     16'($urandom), 16'($urandom), {5'b11011, 11'($urandom)});
         end else if (r == 6) begin
            do_clear();
         end else if (r < 9) begin
            read_env("");
         end else begin
            cfg_prot = 1'($urandom); cfg_seg_zero = 1'($urandom); cfg_opc_always = 1'($urandom);
            step();
         end
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule